// File: doc/BRIEF.md
# Converter Output Select, Mute and Bypass Controller

This block owns the 16-bit word that feeds the converter's output latch. For each output update it chooses what to load. In direct mode it takes the word from the serial holding register. In filtered mode it takes the interpolation filter's result. Three active-low control inputs steer it: bypass, mute and filter reset. These inputs come from pins and are asynchronous, so a two-flop chain samples them into the bit-clock domain before any decision uses them.

Bypass selects unfiltered data but leaves the filter running. A later return to filtered data therefore continues from a filter that never stopped. Mute replaces the loaded word with mid-scale (two's-complement zero) at each update strobe. It does not touch the serial path or the filter, and the first update after mute is released loads a normal value.

Filter reset, taken together with bypass, picks one of three modes:
- Filter reset low with bypass low gives a plain converter fed from the holding register.
- Filter reset low with bypass high parks the output at mid-scale on the next bit-clock edge.
- Filter reset high with bypass high gives filtered output.

The block also drives a filter-run enable, which is low whenever filter reset is active. The filter arithmetic, the serial capture and the generation of the 1.5-bit-clock word strobe all sit outside this block.

Top module: `dac_out_select`

## Requirements
- R1: While rst_n is sampled low at a clock edge, dac_word becomes 16'h0000 (mid-scale) and dac_load becomes 0 after that edge. The controls' synchronised copies reset to their inactive (high) level.
- R2: Direct mode is active when the synchronised bypass is low and filter reset is high. In this mode a high word_upd loads hold_word into dac_word at the next edge, and filt_upd has no effect.
- R3: Filtered mode is active when synchronised bypass and filter reset are both high. In this mode a high filt_upd loads filt_word at the next edge, and word_upd has no effect.
- R4: While synchronised mute is low, every update that the active mode selects loads 16'h0000 instead of the data word.
- R5: The first selected update after synchronised mute returns high loads the normal data word.
- R6: Park mode is active when synchronised filter reset is low and bypass is high. At every edge in park mode, dac_word becomes 16'h0000 and dac_load stays 0, whatever the strobes do.
- R7: When synchronised filter reset and bypass are both low, the block acts as a plain converter: word_upd loads hold_word.
- R8: filt_en follows filter reset through the two-flop delay. It stays high through bypass and mute, so neither of them stops the filter.
- R9: A control input change is first used by the edge two edges after the first edge that samples it. A strobe on the edge in between still uses the old mode.
- R10: Outside park mode, dac_word changes only at an edge where the selected strobe was high.
- R11: dac_load is high for exactly the cycle after each edge at which a selected strobe loaded dac_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| bypass_n | input | 1 | Asynchronous active-low filter bypass |
| mute_n | input | 1 | Asynchronous active-low mute to mid-scale |
| filt_rst_n | input | 1 | Asynchronous active-low filter shutdown |
| hold_word | input | 16 | Holding-register word (two's complement) |
| word_upd | input | 1 | Word update strobe, 1.5 bit clocks after the word-clock fall |
| filt_word | input | 16 | Filter output word |
| filt_upd | input | 1 | Filter update strobe |
| dac_word | output | 16 | Word presented to the output latch |
| dac_load | output | 1 | Pulses for one cycle after each strobe-driven load |
| filt_en | output | 1 | Filter run enable (low while filter reset is active) |

## Verification
The bench looks for wrong priority between park mode and mute or strobes; a faulty design would let a strobe load data while parked. It checks that each mode ignores the other mode's strobe; an inverted select would load filter data in direct mode. It times the two-flop latency exactly, so a design with one flop, or with none, shows the new mode one edge early. It also confirms that bypass and mute leave filt_en high and that the word loaded after mute release is real data; a design that cleared the filter on bypass, or muted one update too many, fails these checks.

// File: rtl/dac_sel_pkg.sv
// Shared types for the output select controller.
// Assumes: output words are two's complement, so mid-scale is zero.
package dac_sel_pkg;

    // Output source chosen from the synchronised reset/bypass pair.
    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,  // holding register on word strobe
        MODE_FILTER = 2'd1,  // filter output on filter strobe
        MODE_PARK   = 2'd2   // held at mid-scale every edge
    } out_mode_e;

    // Bit positions inside the synchronised control vector.
    localparam int CTL_BYP  = 0;
    localparam int CTL_MUTE = 1;
    localparam int CTL_FRST = 2;
    localparam int CTL_N    = 3;

endpackage

// File: rtl/ctl_sync.sv
// Multi-bit level synchroniser for slow, independent control pins.
// Each bit passes through STAGES flops. Reset loads RST_VAL.
// Assumes: bits are unrelated levels, so per-bit skew of one cycle is fine.
module ctl_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= async_in;
    end

    // Remaining stages settle metastability.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/mode_decode.sv
// Decodes the synchronised filter-reset and bypass levels into the output
// mode, and gives the filter its run enable.
// Assumes: inputs are already in the bit-clock domain and active-low.
module mode_decode
    import dac_sel_pkg::*;
(
    input  logic      byp_s_n,
    input  logic      frst_s_n,
    output out_mode_e mode,
    output logic      filt_run
);

    // Truth table: bypass low is direct no matter the filter state.
    always_comb begin
        if (!byp_s_n)       mode = MODE_DIRECT;
        else if (frst_s_n)  mode = MODE_FILTER;
        else                mode = MODE_PARK;
    end

    // Filter runs unless shut down; bypass and mute never stop it.
    assign filt_run = frst_s_n;

endmodule

// File: rtl/out_latch.sv
// Output word register. It loads the selected source at its strobe,
// replaces the word with mid-scale while muted, and forces mid-scale
// on every edge in park mode.
// Assumes: strobes are single-cycle pulses in the bit-clock domain.
module out_latch
    import dac_sel_pkg::*;
#(
    parameter int         W   = 16,
    parameter logic [W-1:0] MID = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  out_mode_e    mode,
    input  logic         mute_s_n,
    input  logic [W-1:0] hold_word,
    input  logic         word_upd,
    input  logic [W-1:0] filt_word,
    input  logic         filt_upd,
    output logic [W-1:0] dac_word,
    output logic         dac_load
);

    logic         sel_upd;
    logic [W-1:0] sel_word;
    logic [W-1:0] load_word;

    // Pick the strobe and the data word that belong to the active mode.
    always_comb begin
        unique case (mode)
            MODE_DIRECT: begin sel_upd = word_upd; sel_word = hold_word; end
            MODE_FILTER: begin sel_upd = filt_upd; sel_word = filt_word; end
            default:     begin sel_upd = 1'b0;     sel_word = MID;       end
        endcase
    end

    // Mute replaces the data at the update, without touching the sources.
    assign load_word = mute_s_n ? sel_word : MID;

    // Register the output word and the load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_word <= MID;
            dac_load <= 1'b0;
        end else if (mode == MODE_PARK) begin
            dac_word <= MID;
            dac_load <= 1'b0;
        end else begin
            dac_load <= sel_upd;
            if (sel_upd) dac_word <= load_word;
        end
    end

endmodule

// File: rtl/dac_out_select.sv
// Top of the output select controller. It synchronises the three
// active-low control pins, decodes the mode and drives the output latch.
// Assumes: clk is the continuous bit clock; the strobes come from the
// serial capture and the filter, already in the clk domain.
module dac_out_select
    import dac_sel_pkg::*;
#(
    parameter int         W         = 16,
    parameter int         SYNC_DEPTH = 2,
    parameter logic [W-1:0] MID     = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bypass_n,
    input  logic         mute_n,
    input  logic         filt_rst_n,
    input  logic [W-1:0] hold_word,
    input  logic         word_upd,
    input  logic [W-1:0] filt_word,
    input  logic         filt_upd,
    output logic [W-1:0] dac_word,
    output logic         dac_load,
    output logic         filt_en
);

    logic [CTL_N-1:0] ctl_raw;
    logic [CTL_N-1:0] ctl_s;
    logic             byp_s;
    logic             mute_s;
    logic             frst_s;
    out_mode_e        mode;

    // Gather the pins into one vector for the synchroniser.
    always_comb begin
        ctl_raw           = '1;
        ctl_raw[CTL_BYP]  = bypass_n;
        ctl_raw[CTL_MUTE] = mute_n;
        ctl_raw[CTL_FRST] = filt_rst_n;
    end

    ctl_sync #(
        .WIDTH  (CTL_N),
        .STAGES (SYNC_DEPTH),
        .RST_VAL({CTL_N{1'b1}})
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ctl_raw),
        .sync_out(ctl_s)
    );

    assign byp_s  = ctl_s[CTL_BYP];
    assign mute_s = ctl_s[CTL_MUTE];
    assign frst_s = ctl_s[CTL_FRST];

    mode_decode dec_i (
        .byp_s_n (byp_s),
        .frst_s_n(frst_s),
        .mode    (mode),
        .filt_run(filt_en)
    );

    out_latch #(
        .W  (W),
        .MID(MID)
    ) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .mute_s_n (mute_s),
        .hold_word(hold_word),
        .word_upd (word_upd),
        .filt_word(filt_word),
        .filt_upd (filt_upd),
        .dac_word (dac_word),
        .dac_load (dac_load)
    );

endmodule

// File: rtl/dac_out_select_chk.sv
// Property checker for dac_out_select, attached by bind. It observes the
// synchronised control levels and the top-level ports.
module dac_out_select_chk #(
    parameter int         W   = 16,
    parameter logic [W-1:0] MID = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         byp_s,
    input logic         mute_s,
    input logic         frst_s,
    input logic [W-1:0] hold_word,
    input logic         word_upd,
    input logic [W-1:0] filt_word,
    input logic         filt_upd,
    input logic [W-1:0] dac_word,
    input logic         dac_load
);

    logic park;
    logic direct;
    logic filt_mode;
    logic sel_upd;

    assign park      = !frst_s && byp_s;
    assign direct    = !byp_s;
    assign filt_mode = frst_s && byp_s;
    assign sel_upd   = (direct && word_upd) || (filt_mode && filt_upd);

    // R2 and R7: direct update loads the holding word.
    assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        direct && mute_s && word_upd |=> dac_word == $past(hold_word));

    // R3: filtered update loads the filter word.
    assert_filter_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        filt_mode && mute_s && filt_upd |=> dac_word == $past(filt_word));

    // R4: muted update loads mid-scale.
    assert_mute_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_s && sel_upd |=> dac_word == MID);

    // R6: park forces mid-scale with no load pulse.
    assert_park_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        park |=> dac_word == MID && !dac_load);

    // R10: no selected strobe, no change outside park.
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !park && !sel_upd |=> $stable(dac_word));

    // R11: a load pulse always follows a selected strobe.
    assert_load_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_upd && !park |=> dac_load);

endmodule

bind dac_out_select dac_out_select_chk #(.W(W), .MID(MID)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .byp_s    (byp_s),
    .mute_s   (mute_s),
    .frst_s   (frst_s),
    .hold_word(hold_word),
    .word_upd (word_upd),
    .filt_word(filt_word),
    .filt_upd (filt_upd),
    .dac_word (dac_word),
    .dac_load (dac_load)
);

// File: tb/dac_out_select_tb_top.sv
// Self-checking bench: vector table walk, then directed corner tests.
module dac_out_select_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bypass_n, mute_n, filt_rst_n;
    logic [15:0] hold_word, filt_word;
    logic        word_upd, filt_upd;
    logic [15:0] dac_word;
    logic        dac_load, filt_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dac_out_select dut_i (
        .clk(clk), .rst_n(rst_n), .bypass_n(bypass_n), .mute_n(mute_n),
        .filt_rst_n(filt_rst_n), .hold_word(hold_word), .word_upd(word_upd),
        .filt_word(filt_word), .filt_upd(filt_upd), .dac_word(dac_word),
        .dac_load(dac_load), .filt_en(filt_en)
    );

    // Fields: bypass_n, mute_n, filt_rst_n, word_upd, filt_upd, hold, filt, expected.
    localparam int NV = 12;
    localparam logic [52:0] VEC [NV] = '{
        {1'b0,1'b1,1'b1,1'b1,1'b0,16'h1234,16'h5555,16'h1234}, // R2
        {1'b0,1'b1,1'b1,1'b0,1'b1,16'h2222,16'h6666,16'h1234}, // R2 filt ignored
        {1'b1,1'b1,1'b1,1'b0,1'b1,16'h3333,16'h7777,16'h7777}, // R3
        {1'b1,1'b1,1'b1,1'b1,1'b0,16'h4444,16'h8888,16'h7777}, // R3 word ignored
        {1'b1,1'b0,1'b1,1'b0,1'b1,16'h9999,16'hAAAA,16'h0000}, // R4
        {1'b1,1'b0,1'b1,1'b0,1'b0,16'h1357,16'h2468,16'h0000}, // R4
        {1'b1,1'b1,1'b1,1'b0,1'b1,16'h1111,16'hABCD,16'hABCD}, // R5
        {1'b0,1'b0,1'b1,1'b1,1'b0,16'h1111,16'h2222,16'h0000}, // R4 direct
        {1'b0,1'b1,1'b0,1'b1,1'b0,16'h8000,16'h3333,16'h8000}, // R7
        {1'b1,1'b1,1'b0,1'b0,1'b0,16'h4444,16'h5555,16'h0000}, // R6
        {1'b1,1'b1,1'b0,1'b1,1'b1,16'h7FFF,16'h7FFF,16'h0000}, // R6
        {1'b0,1'b1,1'b1,1'b1,1'b0,16'h7FFF,16'h0001,16'h7FFF}  // R2
    };

    // One clock edge, then settle to the falling edge for sampling.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare and count one result.
    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bypass_n = 1'b1; mute_n = 1'b1; filt_rst_n = 1'b1;
        hold_word = '0; filt_word = '0; word_upd = 1'b0; filt_upd = 1'b0;
        @(negedge clk);
        step(); step();
        // R1: reset state.
        check("R1 word", dac_word, 16'h0000);
        check("R1 load", {15'b0, dac_load}, 16'h0000);
        rst_n = 1'b1;
        step();

        // Vector table walk.
        for (int i = 0; i < NV; i++) begin
            bypass_n = VEC[i][52]; mute_n = VEC[i][51]; filt_rst_n = VEC[i][50];
            step(); step();  // synchroniser latency
            word_upd = VEC[i][49]; filt_upd = VEC[i][48];
            hold_word = VEC[i][47:32]; filt_word = VEC[i][31:16];
            step();
            word_upd = 1'b0; filt_upd = 1'b0;
            check($sformatf("R2-7 vec%0d", i), dac_word, VEC[i][15:0]);
            check($sformatf("R8 vec%0d", i), {15'b0, filt_en}, {15'b0, VEC[i][50]});
        end

        // R11: load pulse in direct mode lasts one cycle.
        hold_word = 16'h0F0F; word_upd = 1'b1;
        step();
        word_upd = 1'b0;
        check("R11 pulse", {15'b0, dac_load}, 16'h0001);
        step();
        check("R11 drop", {15'b0, dac_load}, 16'h0000);

        // R10: word held between strobes while inputs move.
        hold_word = 16'h5A5A; filt_word = 16'hA5A5; filt_upd = 1'b1;
        step(); step();
        filt_upd = 1'b0;
        check("R10 hold", dac_word, 16'h0F0F);

        // R9: mute change not used by the edge right after the first sample.
        bypass_n = 1'b1;
        step(); step();              // now filtered mode
        filt_word = 16'h0246; filt_upd = 1'b1;
        step();
        check("R3 settle", dac_word, 16'h0246);
        mute_n = 1'b0; filt_word = 16'h1357;
        step();                      // edge 1 samples mute, strobe uses old mode
        filt_word = 16'h2468;
        step();                      // edge 2 still old mode
        check("R9 old mode", dac_word, 16'h2468);
        filt_word = 16'h3579;
        step();                      // edge 3 muted
        filt_upd = 1'b0;
        check("R9 new mode", dac_word, 16'h0000);
        // R8: filter keeps running through bypass and mute.
        bypass_n = 1'b0;
        step(); step(); step();
        check("R8 run in bypass+mute", {15'b0, filt_en}, 16'h0001);
        // R5: first update after release loads data.
        mute_n = 1'b1;
        step(); step();
        hold_word = 16'h7001; word_upd = 1'b1;
        step();
        word_upd = 1'b0;
        check("R5 release", dac_word, 16'h7001);

        // R6 and R8 latency: park applied at the third edge, not before.
        bypass_n = 1'b1; filt_rst_n = 1'b0;
        step();
        check("R8 early", {15'b0, filt_en}, 16'h0001);
        step();
        check("R6 early", dac_word, 16'h7001);
        check("R8 late", {15'b0, filt_en}, 16'h0000);
        step();
        check("R6 park", dac_word, 16'h0000);

        // R1: reset in the middle of operation.
        bypass_n = 1'b0; filt_rst_n = 1'b1;
        step(); step();
        hold_word = 16'h4321; word_upd = 1'b1;
        step();
        word_upd = 1'b0;
        check("R2 reload", dac_word, 16'h4321);
        rst_n = 1'b0;
        step();
        check("R1 midrun", dac_word, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule